// File: doc/BRIEF.md
# Navigation Pack Header Detector

This block watches the user-data portion of each optical-disc video sector as it streams past, one byte per valid beat. It does not search for start codes. It compares a small set of fixed byte positions inside the sector against two expected headers:

- a system-header start code (00 00 01 BB) at byte positions 14 to 17;
- a private-stream packet header (00 00 01 BF) beginning at byte 38.

When every compared byte matches, the sector is taken to be a navigation (search-information) pack. The block then raises a sticky interrupt flag and latches the sub-stream identifier byte that follows the packet header.

The interrupt stays set until the host clears it. To clear it, the host reads its status register while a clear-enable control is high. When the block runs in CD mode it never raises the flag. The input stream has no ready signal because the block never applies back-pressure: a producer may present a beat in any cycle, and a cycle with the valid strobe low is a stall that consumes no byte position.

Top module: `dsi_pack_detect`

## Requirements
- R1: The beat with `s_valid` and `s_sos` both high is byte 0 of a sector. Byte positions advance only on beats with `s_valid` high. Stall cycles do not shift the byte positions.
- R2: Bytes 14, 15, 16 and 17 must equal 8'h00, 8'h00, 8'h01 and 8'hBB. Any other value at one of these positions keeps the sector from being flagged.
- R3: Bytes 38, 39, 40 and 41 must equal 8'h00, 8'h00, 8'h01 and 8'hBF. Bytes 42 and 43 are never compared, so any value there is accepted.
- R4: The decision is made on byte 44. For a matching sector, `dsi_irq` rises in the cycle after the byte-44 beat. It stays low through byte 43.
- R5: `dsi_irq` is sticky. It falls only in the cycle after a beat in which `host_rd` and `clr_en` are both high. Either signal alone has no effect.
- R6: While `cd_mode` is high at the decision beat, neither `dsi_irq` nor `sub_id` changes.
- R7: `sub_id` holds byte 44 of the most recent flagged sector. It is updated by a new flagged sector even while `dsi_irq` is already set.
- R8: If a flagged decision and a clearing read occur in the same cycle, the set wins and `dsi_irq` stays high.
- R9: After reset, `dsi_irq` is 0 and `sub_id` is 8'h00.
- R10: A new start-of-sector beat before byte 44 abandons the partial sector. Matching restarts at byte 0 of the new sector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | A byte is present on `s_data` this cycle |
| s_sos | input | 1 | Marks the current beat as byte 0 of a sector |
| s_data | input | 8 | Stream byte |
| cd_mode | input | 1 | High selects CD operation; detection results are discarded |
| host_rd | input | 1 | One-cycle strobe: the host reads the status register |
| clr_en | input | 1 | Clear-enable control; makes a status read clear the flag |
| dsi_irq | output | 1 | Sticky navigation-pack interrupt flag |
| sub_id | output | 8 | Sub-stream identifier captured from the last flagged sector |

## Verification
A flag set and a flag clear can land in the same cycle. This happens when the host issues its clearing status read on exactly the beat that carries byte 44 of a matching sector. The bench provokes it by first leaving the flag set from an earlier sector, then asserting `host_rd` and `clr_en` together with the byte-44 beat of a second matching sector. The check passes only if the flag is still high on the next cycle and `sub_id` shows the new identifier. A normal clearing read afterwards must then drop the flag, which shows that the clear path itself still works.

// File: rtl/dsi_det_pkg.sv
package dsi_det_pkg;

  // Number of compared positions: four for each of the two headers.
  localparam int unsigned N_MATCH = 8;

  // Byte k (0..3) of a start code 00 00 01 <id>.
  function automatic logic [7:0] start_code_byte(input int unsigned k, input logic [7:0] id);
    logic [7:0] b;
    case (k)
      2:       b = 8'h01;
      3:       b = id;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/dsi_byte_index.sv
module dsi_byte_index #(
  parameter int unsigned SECTOR_BYTES = 2048,
  parameter int unsigned IDX_W        = $clog2(SECTOR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_valid,
  input  logic             beat_sos,
  output logic [IDX_W-1:0] beat_idx,
  output logic             beat_live
);

  localparam logic [IDX_W-1:0] IDLE_IDX = IDX_W'(SECTOR_BYTES);

  // Index of the next byte to arrive; IDLE_IDX means outside any sector.
  logic [IDX_W-1:0] cnt_q;

  assign beat_idx  = beat_sos ? '0 : cnt_q;
  assign beat_live = beat_valid && (beat_idx < IDLE_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= IDLE_IDX;
    end else if (beat_live) begin
      cnt_q <= beat_idx + 1'b1;
    end
  end

  // R1: a start-of-sector beat makes the following byte position 1
  p_sos_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_sos) |=> (cnt_q == IDX_W'(1)));

  // R1: stalls do not move the position
  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |=> $stable(cnt_q));

endmodule

// File: rtl/dsi_hdr_match.sv
module dsi_hdr_match
  import dsi_det_pkg::*;
#(
  parameter int unsigned IDX_W     = 12,
  parameter int unsigned HDR_OFS   = 14,
  parameter int unsigned PKT_OFS   = 38,
  parameter int unsigned SUBID_OFS = 44,
  parameter logic [7:0]  HDR_ID    = 8'hBB,
  parameter logic [7:0]  PKT_ID    = 8'hBF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_valid,
  input  logic             beat_sos,
  input  logic             beat_live,
  input  logic [IDX_W-1:0] beat_idx,
  input  logic [7:0]       beat_data,
  output logic             pack_hit
);

  logic [N_MATCH-1:0] miss;
  logic               veto;
  logic               ok_q;

  for (genvar k = 0; k < N_MATCH; k++) begin : g_cmp
    localparam int unsigned POS   = (k < 4) ? HDR_OFS + k : PKT_OFS + k - 4;
    localparam logic [7:0]  EXPCT = start_code_byte(k % 4, (k < 4) ? HDR_ID : PKT_ID);
    assign miss[k] = beat_live && (beat_idx == IDX_W'(POS)) && (beat_data != EXPCT);
  end

  assign veto     = |miss;
  assign pack_hit = beat_live && (beat_idx == IDX_W'(SUBID_OFS)) && ok_q && !veto;

  // ok_q: no compared byte of the current sector has mismatched so far.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q <= 1'b0;
    end else if (beat_valid && beat_sos) begin
      ok_q <= !veto;
    end else if (veto) begin
      ok_q <= 1'b0;
    end
  end

  // R4: once vetoed, a sector stays vetoed until the next start of sector
  p_veto_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ok_q && !(beat_valid && beat_sos)) |=> !ok_q);

  // R4: a hit only occurs on a live beat
  p_hit_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pack_hit |-> beat_valid);

endmodule

// File: rtl/dsi_irq_ctrl.sv
module dsi_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pack_hit,
  input  logic [7:0] beat_data,
  input  logic       cd_mode,
  input  logic       host_rd,
  input  logic       clr_en,
  output logic       irq,
  output logic [7:0] sub_id
);

  logic take;
  logic wipe;

  assign take = pack_hit && !cd_mode;
  assign wipe = host_rd && clr_en;

  // Set takes priority over clear when both occur in one cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      sub_id <= 8'h00;
    end else if (take) begin
      irq    <= 1'b1;
      sub_id <= beat_data;
    end else if (wipe) begin
      irq    <= 1'b0;
    end
  end

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pack_hit && !cd_mode) |=> irq);

  p_cd_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && cd_mode) |=> !irq);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(host_rd && clr_en)) |=> irq);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && clr_en && !(pack_hit && !cd_mode)) |=> !irq);

  p_id_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pack_hit && !cd_mode) |=> $stable(sub_id));

endmodule

// File: rtl/dsi_pack_detect.sv
module dsi_pack_detect #(
  parameter int unsigned SECTOR_BYTES = 2048,
  parameter int unsigned HDR_OFS      = 14,
  parameter int unsigned PKT_OFS      = 38,
  parameter int unsigned PKT_HDR_LEN  = 6,
  parameter logic [7:0]  HDR_ID       = 8'hBB,
  parameter logic [7:0]  PKT_ID       = 8'hBF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  input  logic       s_sos,
  input  logic [7:0] s_data,
  input  logic       cd_mode,
  input  logic       host_rd,
  input  logic       clr_en,
  output logic       dsi_irq,
  output logic [7:0] sub_id
);

  localparam int unsigned IDX_W     = $clog2(SECTOR_BYTES + 1);
  localparam int unsigned SUBID_OFS = PKT_OFS + PKT_HDR_LEN;

  logic [IDX_W-1:0] beat_idx;
  logic             beat_live;
  logic             pack_hit;

  dsi_byte_index #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .IDX_W        (IDX_W)
  ) u_index (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (s_valid),
    .beat_sos   (s_sos),
    .beat_idx   (beat_idx),
    .beat_live  (beat_live)
  );

  dsi_hdr_match #(
    .IDX_W     (IDX_W),
    .HDR_OFS   (HDR_OFS),
    .PKT_OFS   (PKT_OFS),
    .SUBID_OFS (SUBID_OFS),
    .HDR_ID    (HDR_ID),
    .PKT_ID    (PKT_ID)
  ) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (s_valid),
    .beat_sos   (s_sos),
    .beat_live  (beat_live),
    .beat_idx   (beat_idx),
    .beat_data  (s_data),
    .pack_hit   (pack_hit)
  );

  dsi_irq_ctrl u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pack_hit  (pack_hit),
    .beat_data (s_data),
    .cd_mode   (cd_mode),
    .host_rd   (host_rd),
    .clr_en    (clr_en),
    .irq       (dsi_irq),
    .sub_id    (sub_id)
  );

endmodule

// File: tb/dsi_pack_detect_tb.sv
module dsi_pack_detect_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NBYTES     = 2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_sos = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       cd_mode = 1'b0;
  logic       host_rd = 1'b0;
  logic       clr_en = 1'b0;
  logic       dsi_irq;
  logic [7:0] sub_id;

  int n_chk  = 0;
  int n_fail = 0;

  logic [7:0] sec [0:NBYTES-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  dsi_pack_detect u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_sos   (s_sos),
    .s_data  (s_data),
    .cd_mode (cd_mode),
    .host_rd (host_rd),
    .clr_en  (clr_en),
    .dsi_irq (dsi_irq),
    .sub_id  (sub_id)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill_good(input logic [7:0] sid);
    for (int i = 0; i < NBYTES; i++) sec[i] = 8'(i * 13 + 5);
    sec[14] = 8'h00; sec[15] = 8'h00; sec[16] = 8'h01; sec[17] = 8'hBB;
    sec[38] = 8'h00; sec[39] = 8'h00; sec[40] = 8'h01; sec[41] = 8'hBF;
    sec[42] = 8'h5A; sec[43] = 8'hC3;
    sec[44] = sid;
  endtask

  // Send bytes lo..hi; optional stall after every beat; clearing read on beat rd_at.
  task automatic send_range(input int lo, input int hi, input bit gap, input int rd_at);
    for (int i = lo; i <= hi; i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_sos   = (i == 0);
      s_data  = sec[i];
      host_rd = (i == rd_at);
      clr_en  = (i == rd_at);
      @(posedge clk);
      if (gap) begin
        @(negedge clk);
        s_valid = 1'b0; s_sos = 1'b0; host_rd = 1'b0; clr_en = 1'b0;
        @(posedge clk);
      end
    end
    @(negedge clk);
    s_valid = 1'b0; s_sos = 1'b0; host_rd = 1'b0; clr_en = 1'b0;
  endtask

  task automatic host_read(input bit rd, input bit clr);
    @(negedge clk);
    host_rd = rd; clr_en = clr;
    @(posedge clk);
    @(negedge clk);
    host_rd = 1'b0; clr_en = 1'b0;
  endtask

  task automatic t_reset();
    check(dsi_irq == 1'b0, "R9 irq", dsi_irq, 0);
    check(sub_id == 8'h00, "R9 sub_id", sub_id, 0);
  endtask

  task automatic t_basic_timing();
    fill_good(8'h21);
    send_range(0, 43, 1'b0, -1);
    check(dsi_irq == 1'b0, "R4 low through byte 43", dsi_irq, 0);
    send_range(44, 44, 1'b0, -1);
    check(dsi_irq == 1'b1, "R4 set after byte 44", dsi_irq, 1);
    check(sub_id == 8'h21, "R7 capture", sub_id, 8'h21);
    send_range(45, NBYTES-1, 1'b0, -1);
    check(dsi_irq == 1'b1, "R2 R3 matched sector", dsi_irq, 1);
  endtask

  task automatic t_clear_rules();
    host_read(1'b1, 1'b0);
    check(dsi_irq == 1'b1, "R5 read without clr_en", dsi_irq, 1);
    host_read(1'b0, 1'b1);
    check(dsi_irq == 1'b1, "R5 clr_en without read", dsi_irq, 1);
    host_read(1'b1, 1'b1);
    check(dsi_irq == 1'b0, "R5 clearing read", dsi_irq, 0);
  endtask

  task automatic t_bad_header();
    fill_good(8'h33); sec[16] = 8'h02;
    send_range(0, 60, 1'b0, -1);
    check(dsi_irq == 1'b0, "R2 byte 16 wrong", dsi_irq, 0);
    fill_good(8'h34); sec[17] = 8'hBA;
    send_range(0, 60, 1'b0, -1);
    check(dsi_irq == 1'b0, "R2 byte 17 wrong", dsi_irq, 0);
    fill_good(8'h35); sec[41] = 8'hBE;
    send_range(0, 60, 1'b0, -1);
    check(dsi_irq == 1'b0, "R3 byte 41 wrong", dsi_irq, 0);
    fill_good(8'h36); sec[38] = 8'h80;
    send_range(0, 60, 1'b0, -1);
    check(dsi_irq == 1'b0, "R3 byte 38 wrong", dsi_irq, 0);
    check(sub_id == 8'h21, "R7 no capture on mismatch", sub_id, 8'h21);
  endtask

  task automatic t_dont_care_and_stalls();
    fill_good(8'h47); sec[42] = 8'hFF; sec[43] = 8'h00;
    send_range(0, 60, 1'b1, -1);
    check(dsi_irq == 1'b1, "R1 R3 stalls and free bytes 42-43", dsi_irq, 1);
    check(sub_id == 8'h47, "R1 id with stalls", sub_id, 8'h47);
    host_read(1'b1, 1'b1);
  endtask

  task automatic t_cd_mode();
    cd_mode = 1'b1;
    fill_good(8'h58);
    send_range(0, 60, 1'b0, -1);
    check(dsi_irq == 1'b0, "R6 cd mode no flag", dsi_irq, 0);
    check(sub_id == 8'h47, "R6 cd mode id kept", sub_id, 8'h47);
    cd_mode = 1'b0;
  endtask

  task automatic t_restart();
    fill_good(8'h69); sec[16] = 8'h77;
    send_range(0, 20, 1'b0, -1);
    fill_good(8'h6A);
    send_range(0, 60, 1'b0, -1);
    check(dsi_irq == 1'b1, "R10 restart matches", dsi_irq, 1);
    check(sub_id == 8'h6A, "R10 restart id", sub_id, 8'h6A);
    fill_good(8'h6B);
    send_range(0, 30, 1'b0, -1);
    sec[0] = 8'h00;
    for (int i = 1; i < 30; i++) sec[i] = 8'hEE;
    send_range(0, 60, 1'b0, -1);
    check(sub_id == 8'h6A, "R10 abandoned sector not flagged", sub_id, 8'h6A);
  endtask

  task automatic t_sticky_update();
    fill_good(8'h7C);
    send_range(0, 60, 1'b0, -1);
    check(dsi_irq == 1'b1, "R7 flag stays set", dsi_irq, 1);
    check(sub_id == 8'h7C, "R7 id updated while set", sub_id, 8'h7C);
  endtask

  task automatic t_set_clear_collide();
    fill_good(8'h8D);
    send_range(0, 60, 1'b0, 44);
    check(dsi_irq == 1'b1, "R8 set wins over clear", dsi_irq, 1);
    check(sub_id == 8'h8D, "R8 id on collision", sub_id, 8'h8D);
    host_read(1'b1, 1'b1);
    check(dsi_irq == 1'b0, "R8 later clear works", dsi_irq, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic_timing();
        t_clear_rules();
        t_bad_header();
        t_dont_care_and_stalls();
        t_cd_mode();
        t_restart();
        t_sticky_update();
        t_set_clear_collide();
      end
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule